// File: doc/BRIEF.md
# Clocked Word to Quad-Rail Digit Channel Bridge

This block takes whole words from a clocked producer and sends them out over a delay-insensitive style channel that carries two bits at a time. On the clocked side the producer raises a request; the bridge raises a grant when it is ready. A word is taken on any rising clock edge where both are high.

The bridge then sends the word as a series of 2-bit digits. Each digit is shown on four output rails, and exactly one rail is high to say which of the four values it is. The receiver confirms each digit with an acknowledge line. After that, the bridge returns all rails low, and it waits for the acknowledge to fall before it shows the next digit.

The acknowledge comes from outside the clock domain, so it passes through a flop chain before the sequencer acts on it. The grant stays low until the last digit of the word is complete.

Top module: `s2q_bridge`

## Requirements
- R1: While reset is held and right after it, all four rails are low, `gnt_o` is 1 and `busy_o` is 0.
- R2: A word is taken only on a rising edge where `req_i` and `gnt_o` are both 1. From that edge on, `busy_o` is 1 and `gnt_o` is 0. With `req_i` low the bridge stays idle.
- R3: During a digit, the rail `rail_o[k]` that is high is the one for digit value k (value 0 is bit 0 and value 3 is bit 3). No other rail is high at the same time.
- R4: Digits go out least significant first. Digit i of a 36-bit word is bits [2i+1:2i], which gives 18 digits per word. The first digit is on the rails in the cycle after the word is taken.
- R5: A digit stays on the rails, unchanged, until the acknowledge has been seen high. After that all rails stay low until the acknowledge has been seen low.
- R6: The acknowledge passes through two synchronizer flops. The rails go low on the third rising edge after `ack_i` rises. The next digit appears on the third rising edge after `ack_i` falls.
- R7: While digits remain to be sent, `gnt_o` stays 0, and `req_i` and `word_i` have no effect on the digits sent.
- R8: On the third rising edge after `ack_i` falls for the last digit, `busy_o` falls to 0 and `gnt_o` rises to 1, with the rails low.
- R9: At no time are two or more rails high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Producer request |
| word_i | input | 36 | Word offered by the producer |
| gnt_o | output | 1 | Grant, high when a new word can be taken |
| busy_o | output | 1 | High while digits of a word remain to be sent |
| rail_o | output | 4 | One-of-four digit rails, all low when neutral |
| ack_i | input | 1 | Acknowledge from the receiver, not synchronous to clk |

## Verification
A wrong digit count or a bad shift register shows at the rails as a wrong value in the next digit that is shown. A word that ends early or late shows as `busy_o` or `gnt_o` changing at the wrong edge at the end of the word. A bad state in the sequencer or the synchronizer shows within three edges of an acknowledge change: the rails drop, or a digit appears, one edge early or late. The bench samples each of these edges one at a time, and it keeps a changing `word_i` and `req_i` on the inputs while a word is being sent, so that any leak from those inputs shows in the digits.

// File: rtl/s2q_pkg.sv
package s2q_pkg;

    localparam int RAIL_N  = 4;
    localparam int DIGIT_W = 2;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_DRIVE   = 2'd1,
        PH_RELEASE = 2'd2
    } phase_e;

    typedef struct packed {
        logic load;
        logic step;
        logic drive;
    } seq_ctl_t;

    function automatic logic [RAIL_N-1:0] digit_to_rails(input logic [DIGIT_W-1:0] d);
        return RAIL_N'(1) << d;
    endfunction

endpackage

// File: rtl/s2q_ack_sync.sv
module s2q_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[g] <= 1'b0;
                end else if (g == 0) begin
                    chain_q[g] <= async_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/s2q_digit_shifter.sv
module s2q_digit_shifter
    import s2q_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               last_o
);
    localparam int DIGITS = WORD_W / DIGIT_W;
    localparam int CNT_W  = $clog2(DIGITS + 1);

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            word_q <= word_i;
            left_q <= CNT_W'(DIGITS);
        end else if (step_i) begin
            word_q <= word_q >> DIGIT_W;
            left_q <= left_q - 1'b1;
        end
    end

    assign digit_o = word_q[DIGIT_W-1:0];
    assign last_o  = (left_q == CNT_W'(1));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        left_q <= CNT_W'(DIGITS));

    // R4
    step_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (left_q > CNT_W'(1)));
endmodule

// File: rtl/s2q_phase_fsm.sv
module s2q_phase_fsm
    import s2q_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_i,
    input  logic     ack_s_i,
    input  logic     last_i,
    output logic     gnt_o,
    output logic     busy_o,
    output seq_ctl_t ctl_o
);
    phase_e ph_q, ph_d;

    always_comb begin
        ph_d       = ph_q;
        ctl_o      = '0;
        ctl_o.drive = (ph_q == PH_DRIVE);
        unique case (ph_q)
            PH_IDLE: begin
                if (req_i) begin
                    ctl_o.load = 1'b1;
                    ph_d       = PH_DRIVE;
                end
            end
            PH_DRIVE: begin
                if (ack_s_i) ph_d = PH_RELEASE;
            end
            PH_RELEASE: begin
                if (!ack_s_i) begin
                    if (last_i) begin
                        ph_d = PH_IDLE;
                    end else begin
                        ctl_o.step = 1'b1;
                        ph_d       = PH_DRIVE;
                    end
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign gnt_o  = (ph_q == PH_IDLE);
    assign busy_o = (ph_q != PH_IDLE);

    // R5
    wait_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_RELEASE && ack_s_i) |=> (ph_q == PH_RELEASE));
endmodule

// File: rtl/s2q_bridge.sv
module s2q_bridge
    import s2q_pkg::*;
#(
    parameter int WORD_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              gnt_o,
    output logic              busy_o,
    output logic [RAIL_N-1:0] rail_o,
    input  logic              ack_i
);
    logic               ack_s;
    logic               last;
    logic [DIGIT_W-1:0] digit;
    seq_ctl_t           ctl;

    s2q_ack_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ack_i),
        .sync_o  (ack_s)
    );

    s2q_phase_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .ack_s_i (ack_s),
        .last_i  (last),
        .gnt_o   (gnt_o),
        .busy_o  (busy_o),
        .ctl_o   (ctl)
    );

    s2q_digit_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ctl.load),
        .step_i  (ctl.step),
        .word_i  (word_i),
        .digit_o (digit),
        .last_o  (last)
    );

    assign rail_o = ctl.drive ? digit_to_rails(digit) : '0;

    // R9
    rails_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rail_o));

    // R5
    digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_o != '0 && !ack_s) |=> (rail_o == $past(rail_o)));

    // R5
    neutral_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_o != '0 && ack_s) |=> (rail_o == '0));

    // R2
    take_word_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && gnt_o) |=> (busy_o && !gnt_o && rail_o != '0));
endmodule

// File: tb/test_s2q_bridge.sv
module test_s2q_bridge;
    localparam int W = 36;
    localparam int D = W / 2;
    localparam logic [W-1:0] VEC [6] = '{
        36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'h1_2345_6789,
        36'hA_5A5A_5A5A, 36'h0_0000_0001, 36'h8_E4E4_1B1B
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic ack = 1'b0;
    logic [W-1:0] word = '0;
    logic gnt, busy;
    logic [3:0] rail;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    s2q_bridge #(.WORD_W(W)) i_s2q_bridge (
        .clk(clk), .rst(rst), .req_i(req), .word_i(word),
        .gnt_o(gnt), .busy_o(busy), .rail_o(rail), .ack_i(ack)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_word(input logic [W-1:0] w, input int k);
        req  = 1'b1;
        word = w;
        tick();
        check(busy && !gnt, "R2 accept", {34'b0, busy, gnt}, 36'h2);
        word = ~w;  // R7: changing input while busy must not leak
        for (int i = 0; i < D; i++) begin
            logic [3:0] exp_r;
            int dly;
            exp_r = 4'b0001 << w[2*i +: 2];
            dly = (i + k) % 3;
            check(rail == exp_r, "R4 digit order / R3 rail code", {32'b0, rail}, {32'b0, exp_r});
            check($countones(rail) == 1, "R9 single rail", {32'b0, rail}, {32'b0, exp_r});
            for (int j = 0; j < dly; j++) begin
                tick();
                check(rail == exp_r, "R5 hold until ack", {32'b0, rail}, {32'b0, exp_r});
            end
            ack = 1'b1;
            tick(); tick();
            check(rail == exp_r, "R6 hold two edges after ack rise", {32'b0, rail}, {32'b0, exp_r});
            if (i == D-1) req = 1'b0;
            tick();
            check(rail == 4'b0, "R6 neutral third edge", {32'b0, rail}, 36'h0);
            for (int j = 0; j <= dly; j++) begin
                tick();
                check(rail == 4'b0, "R5 neutral until ack low", {32'b0, rail}, 36'h0);
            end
            ack = 1'b0;
            tick(); tick();
            check(rail == 4'b0 && busy && !gnt, "R7 grant low while digits remain", {32'b0, rail}, 36'h0);
            tick();
            if (i == D-1) begin
                check(!busy && gnt && rail == 4'b0, "R8 word end", {34'b0, busy, gnt}, 36'h1);
            end
        end
    endtask

    initial begin
        repeat (3) tick();
        check(rail == 4'b0 && gnt && !busy, "R1 reset state", {32'b0, rail}, 36'h0);
        rst = 1'b0;
        tick();
        check(rail == 4'b0 && gnt && !busy, "R1 after reset", {32'b0, rail}, 36'h0);
        word = 36'h5_5555_5555;
        repeat (3) tick();
        check(!busy && gnt && rail == 4'b0, "R2 no request no accept", {34'b0, busy, gnt}, 36'h1);

        for (int v = 0; v < 6; v++) send_word(VEC[v], v);

        req = 1'b1; word = 36'h3_0000_0003;
        tick();
        req = 1'b0;
        check(rail == 4'b1000, "R4 first digit on accept", {32'b0, rail}, 36'h8);
        rst = 1'b1;
        tick();
        check(rail == 4'b0 && gnt && !busy, "R1 reset mid-word", {32'b0, rail}, 36'h0);
        rst = 1'b0;
        tick();
        check(rail == 4'b0 && gnt && !busy, "R1 idle after mid-word reset", {32'b0, rail}, 36'h0);

        send_word(36'h9_8765_4321, 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule